// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between time slots of sixteen serial time-division streams. Each input stream is deserialized into bytes, and each byte is stored in a banked data memory by stream and channel. For every output stream and channel, a connection word chooses one of two sources. The first is a switched byte, taken from any input stream and channel. The second is a fixed message byte held in the word itself. The chosen byte is then shifted back out as serial data.

The throughput delay has two modes. In variable mode a byte takes the shortest path the slot positions allow. In constant mode every connection has the same two-frame delay. Each connection word also holds a per-channel output enable and a per-channel loopback. A synchronous write port loads the connection memory.

The channel count per stream is set by the parameter `RATE`: 32 channels for 0, 64 for 1 and 128 for 2. The block clock runs at twice the bit rate, so each serial bit lasts two clock cycles.

Top module: `tsi_switch`

## Requirements
- R1: While `rst` is high, and after it falls until programmed, every connection word is cleared (output disabled), so every `st_hiz_o` bit is 1 and every `st_o` bit is 1.
- R2: A one-cycle pulse on `frame_i` makes the next clock cycle the first cycle of bit 7 of channel 0. Each bit lasts two clock cycles. Bits leave MSB first. Inputs are sampled in the second cycle of each bit. A frame holds `32<<RATE` channels.
- R3: Connection word fields: bit 15 = output enable, bit 14 = message select, bit 13 = loopback, bits [10:7] = source stream, bits [CHW-1:0] = source channel (CHW = 5+RATE). Channel bits at or above CHW within [6:0] are ignored. The write address is {output stream, output channel}.
- R4: When the output enable bit is 0, `st_hiz_o` for that stream is 1 for the whole channel and `st_o` is held at 1.
- R5: When message select is 1, bits [7:0] of the word are sent on the channel.
- R6: In variable mode, input byte (s,n) appears on output channel m after d slots. d is the smallest number that is at least 3 and congruent to m-n modulo the channel count. So it is m-n when m>n+2, and otherwise it wraps into a later frame.
- R7: In constant mode, the byte received on input channel n of frame f appears on output channel m of frame f+2, for every n and m.
- R8: When the loopback bit of output stream N channel m is 1, the byte sent there replaces the byte received on input stream N channel m, and the pin value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | Frame alignment pulse, one cycle before the frame |
| const_dly_i | input | 1 | 1 selects constant-delay mode, 0 variable |
| st_i | input | 16 | Serial input streams |
| cm_we | input | 1 | Connection memory write strobe |
| cm_addr | input | 4+CHW | {output stream, output channel} |
| cm_wdata | input | 16 | Connection word |
| st_o | output | 16 | Serial output streams |
| st_hiz_o | output | 16 | Per-stream high-impedance indication for the current channel |

## Verification
A wrong bank choice shows as a byte from the wrong frame on the switched channels. In variable mode this appears on channel pairs whose slot distance sits near 3, or near a multiple of the channel count. In constant mode it appears on any channel. A slip in the slot counter, or in the fetch lead, corrupts every checked channel within one frame. A decode error in the connection word shows up within a frame as a wrong tristate pattern or a wrong message byte. A broken loopback path shows within the same frame on a channel that switches from the looped slot.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int OE_BIT  = 15;
  localparam int MSG_BIT = 14;
  localparam int LB_BIT  = 13;
  localparam int SST_LSB = 7;
  localparam int WORD_W  = 16;

  function automatic logic [1:0] bank_next(input logic [1:0] b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

  function automatic logic [1:0] bank_prev(input logic [1:0] b);
    return (b == 2'd0) ? 2'd2 : b - 2'd1;
  endfunction

  // cst: constant mode; wrap: fetched channel belongs to next frame;
  // older: source slot not yet written in the current frame
  function automatic logic [1:0] src_bank(input logic [1:0] cur, input logic cst,
                                          input logic wrap, input logic older);
    if (cst) return wrap ? bank_prev(cur) : bank_next(cur);
    return older ? bank_prev(cur) : cur;
  endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int CHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_i,
  output logic [CHW+3:0] cnt_o,
  output logic [1:0]     bank_o,
  output logic           ph_o,
  output logic           eoc_o,
  output logic [CHW-1:0] chan_o
);
  localparam int CW = CHW + 4;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [1:0]    bank_q;

  assign cnt_nx = frame_i ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bank_q <= 2'd0;
    end else begin
      cnt_q <= cnt_nx;
      if (cnt_nx == '0) bank_q <= tsi_pkg::bank_next(bank_q);
    end
  end

  assign cnt_o  = cnt_q;
  assign bank_o = bank_q;
  assign ph_o   = cnt_q[0];
  assign eoc_o  = cnt_q[0] & (cnt_q[3:1] == 3'd7);
  assign chan_o = cnt_q[CW-1:4];
endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane (
  input  logic       clk,
  input  logic       rst,
  input  logic       ph,
  input  logic       in_bit,
  output logic [7:0] byte_o
);
  logic [6:0] sh_q;
  always_ff @(posedge clk) begin
    if (rst)     sh_q <= '0;
    else if (ph) sh_q <= {sh_q[5:0], in_bit};
  end
  assign byte_o = {sh_q, in_bit};
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane (
  input  logic       clk,
  input  logic       rst,
  input  logic       ph,
  input  logic       eoc,
  input  logic [7:0] fetch_byte,
  input  logic       fetch_oe,
  input  logic       fetch_lb,
  output logic       bit_o,
  output logic       hiz_o,
  output logic       lb_o
);
  logic [7:0] hold_b, sh_q;
  logic       hold_oe, hold_lb, oe_q, lb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_b <= 8'hFF; hold_oe <= 1'b0; hold_lb <= 1'b0;
      sh_q   <= 8'hFF; oe_q    <= 1'b0; lb_q    <= 1'b0;
    end else if (eoc) begin
      sh_q    <= hold_b;
      oe_q    <= hold_oe;
      lb_q    <= hold_lb;
      hold_b  <= fetch_byte;
      hold_oe <= fetch_oe;
      hold_lb <= fetch_lb;
    end else if (ph) begin
      sh_q <= {sh_q[6:0], 1'b1};
    end
  end

  assign bit_o = sh_q[7];
  assign hiz_o = ~oe_q;
  assign lb_o  = lb_q;
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int RATE = 0,
  parameter int NSTR = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_i,
  input  logic                        const_dly_i,
  input  logic [NSTR-1:0]             st_i,
  input  logic                        cm_we,
  input  logic [$clog2(NSTR)+4+RATE:0] cm_addr,
  input  logic [15:0]                 cm_wdata,
  output logic [NSTR-1:0]             st_o,
  output logic [NSTR-1:0]             st_hiz_o
);
  import tsi_pkg::*;
  localparam int CHW = 5 + RATE;
  localparam int CH  = 1 << CHW;
  localparam int SW  = $clog2(NSTR);
  localparam int AW  = SW + CHW;
  localparam int CW  = CHW + 4;
  localparam int NW  = NSTR * CH;

  logic [CW-1:0]  cnt_w;
  logic [1:0]     bank_w;
  logic           ph_w, eoc_w, wrap_w;
  logic [CHW-1:0] chan_w, rf_w;

  tsi_timing #(.CHW(CHW)) u_tim (
    .clk(clk), .rst(rst), .frame_i(frame_i), .cnt_o(cnt_w), .bank_o(bank_w),
    .ph_o(ph_w), .eoc_o(eoc_w), .chan_o(chan_w)
  );

  // fetch runs two channels ahead of the channel being sent
  assign rf_w   = chan_w + CHW'(2);
  assign wrap_w = (chan_w > CHW'(CH - 3));

  logic [WORD_W-1:0] cm [NW];
  logic [7:0]        dm [0:2][NW];
  logic [7:0]        rx_byte [NSTR];
  logic [NSTR-1:0]   tx_bit, tx_lb;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) cm[i] <= '0;
    end else if (cm_we) begin
      cm[cm_addr] <= cm_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (eoc_w)
      for (int i = 0; i < NSTR; i++) dm[bank_w][{SW'(i), chan_w}] <= rx_byte[i];
  end

  for (genvar s = 0; s < NSTR; s++) begin : g_lane
    logic [WORD_W-1:0] word;
    logic [SW-1:0]     src_s;
    logic [CHW-1:0]    src_n;
    logic [1:0]        bk;
    logic [7:0]        nbyte;

    assign word  = cm[{SW'(s), rf_w}];
    assign src_s = word[SST_LSB +: SW];
    assign src_n = word[CHW-1:0];
    assign bk    = src_bank(bank_w, const_dly_i, wrap_w, src_n >= chan_w);
    assign nbyte = word[MSG_BIT] ? word[7:0] : dm[bk][{src_s, src_n}];

    tsi_rx_lane u_rx (
      .clk(clk), .rst(rst), .ph(ph_w),
      .in_bit(tx_lb[s] ? tx_bit[s] : st_i[s]), .byte_o(rx_byte[s])
    );

    tsi_tx_lane u_tx (
      .clk(clk), .rst(rst), .ph(ph_w), .eoc(eoc_w), .fetch_byte(nbyte),
      .fetch_oe(word[OE_BIT]), .fetch_lb(word[LB_BIT]),
      .bit_o(tx_bit[s]), .hiz_o(st_hiz_o[s]), .lb_o(tx_lb[s])
    );

    assign st_o[s] = st_hiz_o[s] | tx_bit[s];
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NSTR = 16,
  parameter int CW   = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_i,
  input logic [NSTR-1:0] st_o,
  input logic [NSTR-1:0] st_hiz_o,
  input logic            ph_w,
  input logic            eoc_w,
  input logic [CW-1:0]   cnt_w,
  input logic [1:0]      bank_w
);
  // R2
  frame_align_chk: assert property (@(posedge clk) disable iff (rst)
    frame_i |=> (cnt_w == '0));
  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ph_w |=> $stable(st_o));
  // R4
  hiz_channel_chk: assert property (@(posedge clk) disable iff (rst)
    !eoc_w |=> $stable(st_hiz_o));
  // R1
  reset_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&st_hiz_o));
  // R7
  bank_range_chk: assert property (@(posedge clk) disable iff (rst)
    bank_w != 2'd3);
endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .frame_i(frame_i), .st_o(st_o), .st_hiz_o(st_hiz_o),
  .ph_w(ph_w), .eoc_w(eoc_w), .cnt_w(cnt_w), .bank_w(bank_w)
);

// File: tb/tsi_switch_test.sv
`timescale 1ns/1ps
module tsi_switch_test;
  localparam int NSTR = 16;
  localparam int CH   = 32;
  localparam int NV   = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1, frame_i = 1'b0, const_dly_i = 1'b0, cm_we = 1'b0;
  logic [15:0] st_i = '0, cm_wdata = '0;
  logic [8:0]  cm_addr = '0;
  logic [15:0] st_o, st_hiz_o;

  always #2 clk = ~clk;

  tsi_switch uut (
    .clk(clk), .rst(rst), .frame_i(frame_i), .const_dly_i(const_dly_i), .st_i(st_i),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata), .st_o(st_o), .st_hiz_o(st_hiz_o)
  );

  // {output stream, output channel, connection word}
  localparam logic [24:0] VEC [NV] = '{
    {4'd0,  5'd10, 16'h8104},   // from (2,4), m-n=6
    {4'd1,  5'd4,  16'h8283},   // from (5,3), m-n=1
    {4'd2,  5'd6,  16'h8003},   // from (0,3), m-n=3
    {4'd3,  5'd5,  16'h8383},   // from (7,3), m-n=2
    {4'd4,  5'd0,  16'h879F},   // from (15,31), delay 33
    {4'd5,  5'd7,  16'hC0C3},   // message C3
    {4'd6,  5'd9,  16'hE03C},   // message 3C with loopback
    {4'd7,  5'd20, 16'h8309},   // from looped (6,9)
    {4'd8,  5'd31, 16'h0081},   // disabled
    {4'd9,  5'd2,  16'h8482},   // from (9,2), m-n=0
    {4'd15, 5'd31, 16'h8020}    // from (0,0), ignored channel bit 5
  };

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] bcm [NSTR][CH];

  function automatic logic [7:0] pat(int sc, int f, int s, int n);
    return 8'(((sc * 71 + f * 29 + s * 11 + n * 7) ^ 8'h96));
  endfunction

  function automatic logic [7:0] src_val(int sc, int f, int ss, int n);
    logic [15:0] w = bcm[ss][n];
    if (w[13] && w[14]) return w[7:0];
    return pat(sc, f, ss, n);
  endfunction

  function automatic logic [7:0] exp_byte(int sc, int f, int s, int m, bit cst);
    logic [15:0] w = bcm[s][m];
    int ss, n, d, fr;
    if (!w[15]) return 8'hFF;
    if (w[14]) return w[7:0];
    ss = int'(w[10:7]);
    n  = int'(w[4:0]);
    d  = m - n;
    if (cst)              fr = f - 2;
    else if (d >= 3)      fr = f;
    else if (d + CH >= 3) fr = f - 1;
    else                  fr = f - 2;
    return src_val(sc, fr, ss, n);
  endfunction

  function automatic string tag(int s, int m, bit cst);
    logic [15:0] w = bcm[s][m];
    if (w == 16'h0) return "R1";
    if (!w[15]) return "R4";
    if (w[14]) return "R2 R5";
    if (w[4:0] != w[6:0]) return "R3";
    if (bcm[int'(w[10:7])][int'(w[4:0])][13]) return "R8";
    return cst ? "R7" : "R6";
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_scn(int sc, bit cst);
    logic [7:0] ob [NSTR];
    logic [7:0] hz [NSTR];
    rst = 1'b1; const_dly_i = cst; cm_we = 1'b0; st_i = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check("R1", st_hiz_o, 16'hFFFF, "hiz after reset");
    check("R1", st_o, 16'hFFFF, "data after reset");
    @(posedge clk); #1;
    for (int s = 0; s < NSTR; s++)
      for (int m = 0; m < CH; m++) bcm[s][m] = '0;
    for (int v = 0; v < NV; v++) begin
      bcm[int'(VEC[v][24:21])][int'(VEC[v][20:16])] = VEC[v][15:0];
      cm_we = 1'b1; cm_addr = VEC[v][24:16]; cm_wdata = VEC[v][15:0];
      @(posedge clk); #1;
    end
    cm_we = 1'b0;
    frame_i = 1'b1;
    @(posedge clk); #1;
    frame_i = 1'b0;
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < CH * 16; t++) begin
        int ch = t >> 4;
        int b  = (t >> 1) & 7;
        for (int s = 0; s < NSTR; s++) st_i[s] = pat(sc, f, s, ch)[7 - b];
        @(negedge clk);
        if (t & 1) begin
          for (int s = 0; s < NSTR; s++) begin
            ob[s][7 - b] = st_o[s];
            hz[s][7 - b] = st_hiz_o[s];
          end
          if (b == 7 && f >= 2) begin
            for (int s = 0; s < NSTR; s++) begin
              logic ehz = ~bcm[s][ch][15];
              string rq = tag(s, ch, cst);
              check(rq, {8'h0, ob[s]}, {8'h0, exp_byte(sc, f, s, ch, cst)},
                    $sformatf("byte s%0d ch%0d f%0d", s, ch, f));
              check(ehz ? "R4" : rq, {8'h0, hz[s]}, {8'h0, {8{ehz}}},
                    $sformatf("hiz s%0d ch%0d f%0d", s, ch, f));
            end
          end
        end
        @(posedge clk); #1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    run_scn(0, 1'b0);   // variable delay, R6
    run_scn(1, 1'b1);   // constant delay, R7
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule